// File: doc/BRIEF.md
# Immediate-Operand Fetch Sequencer

This block sits directly behind the opcode register of a small processor front end. It takes one 16-bit opcode at a time and sorts it into one of a few classes. An OR-with-immediate opcode makes it pull one or two 16-bit extension words from the instruction stream. It then assembles the immediate value at the operation's width and reports that value to the execution stage with a single-cycle pulse. The no-operation opcode is handled as a pipeline barrier: the sequencer waits until the bus reports no outstanding cycles, then advances the program counter and changes nothing else.

The block keeps its own program counter, which steps by one word (2) for every instruction-stream word it consumes. Opcodes outside its scope are accepted and stepped over without any other effect. Decoding them is the job of other logic.

Top module: `imm_fetch_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, `op_ready` is 1, `ext_ready`, `imm_valid`, `illegal` and `nop_done` are 0, `pc` equals `PC_RESET` (default 0x1000), and `imm_value` is 0.
- R2: An opcode is accepted on a cycle where `op_valid` and `op_ready` are both high. It is an immediate opcode when bits 15..8 are 0x00, and bits 7..6 then give its size. Acceptance raises `pc` by 2.
- R3: Size code 00 (byte) consumes one extension word, and `imm_value` is that word's bits 7..0 zero-extended to 32 bits.
- R4: Size code 01 (word) consumes one extension word, and `imm_value` is the whole word zero-extended to 32 bits.
- R5: Size code 10 (long) consumes two extension words. The first word forms bits 31..16 of `imm_value` and the second forms bits 15..0.
- R6: Size code 11 on an immediate opcode makes `illegal` high for exactly the cycle after acceptance. No extension word is requested, and `pc` advances only by the 2 of the opcode.
- R7: An extension word is taken only on a cycle with `ext_valid` and `ext_ready` both high. While `ext_valid` is low the sequencer holds: `ext_ready` stays high, `pc` does not change and no pulse appears.
- R8: `pc` changes only in steps of +2. There is one step per word consumed, whether opcode or extension word.
- R9: In the cycle after the last extension word is taken, `imm_valid` is high for exactly one cycle and `imm_size` carries the size code. In that same cycle `op_ready` is already 1 again.
- R10: Opcode 0x4E71 (no-operation) keeps `op_ready` low while `bus_pending` is high and leaves `pc` unchanged during the wait. After the first cycle in which `bus_pending` is low, `nop_done` pulses for one cycle and `pc` rises by 2. `imm_value` is not changed.
- R11: Any other opcode is accepted with a `pc` step of 2. It requests no extension word and produces no pulse on `imm_valid`, `illegal` or `nop_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode word present |
| opcode | input | 16 | Opcode word |
| op_ready | output | 1 | Sequencer idle, can take an opcode |
| bus_pending | input | 1 | Outstanding bus cycles exist |
| ext_valid | input | 1 | Extension word present |
| ext_data | input | 16 | Extension word |
| ext_ready | output | 1 | Sequencer requests an extension word |
| imm_valid | output | 1 | One-cycle operand-ready pulse |
| imm_value | output | 32 | Assembled immediate, zero-extended |
| imm_size | output | 2 | Size code of the delivered immediate |
| illegal | output | 1 | One-cycle pulse for size code 11 |
| nop_done | output | 1 | One-cycle pulse when the barrier completes |
| pc | output | 32 | Program counter |

## Verification
The assertions assume that `pc` is never reloaded from outside, so every change to it must be a +2 step. They also assume that `bus_pending` is meaningful only while the barrier waits. The bench drives inputs only on falling edges and withdraws `op_valid` and `ext_valid` one cycle after the handshake. It sweeps every size code over several data patterns with zero to two stall cycles before each word, so all handshakes stay single-beat. It holds `bus_pending` high for zero to three cycles around the barrier.

// File: rtl/imm_seq_pkg.sv
// Shared types for the immediate-operand fetch sequencer.
// Assumes 2-bit size codes as carried in opcode bits 7..6.
package imm_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_BARRIER = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } op_size_t;

    typedef enum logic [1:0] {
        CL_OTHER   = 2'd0,
        CL_IMM     = 2'd1,
        CL_BADSIZE = 2'd2,
        CL_NOP     = 2'd3
    } op_class_t;
endpackage

// File: rtl/imm_decode.sv
// Opcode classifier: sorts an opcode into immediate / bad size / barrier / other,
// and gives the size code and the extension-word count.
// Assumes the immediate class is recognised by a zero upper byte.
module imm_decode
    import imm_seq_pkg::*;
#(
    parameter int          WORD_W   = 16,
    parameter logic [15:0] NOP_CODE = 16'h4E71
) (
    input  logic [WORD_W-1:0] opcode,
    output op_class_t         cls,
    output op_size_t          size,
    output logic [1:0]        words
);
    localparam int HI_LSB = 8;

    // Purpose: pure combinational classification of one opcode word.
    always_comb begin
        size  = op_size_t'(opcode[7:6]);
        words = 2'd0;
        cls   = CL_OTHER;
        if (opcode == WORD_W'(NOP_CODE)) begin
            cls = CL_NOP;
        end else if (opcode[WORD_W-1:HI_LSB] == '0) begin
            if (size == SZ_BAD) begin
                cls = CL_BADSIZE;
            end else begin
                cls   = CL_IMM;
                words = (size == SZ_LONG) ? 2'd2 : 2'd1;
            end
        end
    end
endmodule

// File: rtl/imm_assemble.sv
// Immediate builder: keeps the first extension word and forms the final
// zero-extended value when the last word arrives; pulses valid for one cycle.
// Assumes 'last' is only raised together with 'load'.
module imm_assemble
    import imm_seq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic                last,
    input  op_size_t            size,
    input  logic [WORD_W-1:0]   word_in,
    output logic [2*WORD_W-1:0] value,
    output logic                valid
);
    localparam int HALF_W = WORD_W / 2;
    localparam int IMM_W  = 2 * WORD_W;

    logic [WORD_W-1:0] held_q;
    logic [IMM_W-1:0]  formed;

    // Purpose: size the value from the held word and the arriving word.
    always_comb begin
        unique case (size)
            SZ_BYTE: formed = IMM_W'(word_in[HALF_W-1:0]);
            SZ_WORD: formed = IMM_W'(word_in);
            default: formed = {held_q, word_in};
        endcase
    end

    // Purpose: hold the first word, register the result and its pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            value  <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= load && last;
            if (clear) begin
                held_q <= '0;
            end else if (load) begin
                held_q <= word_in;
            end
            if (load && last) begin
                value <= formed;
            end
        end
    end
endmodule

// File: rtl/imm_pc_counter.sv
// Program counter: steps by one word (in bytes) on each increment request.
// Assumes no external reload path.
module imm_pc_counter #(
    parameter int          PC_W     = 32,
    parameter int          WORD_W   = 16,
    parameter logic [31:0] PC_RESET = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [PC_W-1:0] pc
);
    localparam int STEP_BYTES = WORD_W / 8;

    // Purpose: reset to the start address, then advance per consumed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= PC_W'(PC_RESET);
        end else if (step) begin
            pc <= pc + PC_W'(STEP_BYTES);
        end
    end
endmodule

// File: rtl/imm_fetch_seq.sv
// Top: takes opcodes, fetches immediate extension words with a valid/ready
// handshake, delivers the sized immediate, and runs the no-op bus barrier.
// Assumes opcode and extension words are 16 bits and the PC is owned here.
module imm_fetch_seq
    import imm_seq_pkg::*;
#(
    parameter int          WORD_W   = 16,
    parameter int          PC_W     = 32,
    parameter logic [31:0] PC_RESET = 32'h0000_1000,
    parameter logic [15:0] NOP_CODE = 16'h4E71
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [WORD_W-1:0]   opcode,
    output logic                op_ready,
    input  logic                bus_pending,
    input  logic                ext_valid,
    input  logic [WORD_W-1:0]   ext_data,
    output logic                ext_ready,
    output logic                imm_valid,
    output logic [2*WORD_W-1:0] imm_value,
    output logic [1:0]          imm_size,
    output logic                illegal,
    output logic                nop_done,
    output logic [PC_W-1:0]     pc
);
    seq_state_t state_q;
    op_class_t  dec_cls;
    op_size_t   dec_size;
    op_size_t   size_q;
    logic [1:0] dec_words;
    logic [1:0] left_q;
    logic       accept, take, last, leave_nop, pc_step;

    imm_decode #(.WORD_W(WORD_W), .NOP_CODE(NOP_CODE)) u_dec (
        .opcode (opcode),
        .cls    (dec_cls),
        .size   (dec_size),
        .words  (dec_words)
    );

    // Purpose: handshake and step decisions for the current cycle.
    always_comb begin
        op_ready  = (state_q == ST_IDLE);
        ext_ready = (state_q == ST_FETCH);
        accept    = op_valid && op_ready;
        take      = ext_valid && ext_ready;
        last      = take && (left_q == 2'd1);
        leave_nop = (state_q == ST_BARRIER) && !bus_pending;
        pc_step   = take || leave_nop || (accept && dec_cls != CL_NOP);
    end

    // Purpose: sequence state, remaining word count, size and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            left_q   <= 2'd0;
            size_q   <= SZ_BYTE;
            illegal  <= 1'b0;
            nop_done <= 1'b0;
        end else begin
            illegal  <= accept && (dec_cls == CL_BADSIZE);
            nop_done <= leave_nop;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_cls == CL_IMM) begin
                            state_q <= ST_FETCH;
                            left_q  <= dec_words;
                            size_q  <= dec_size;
                        end else if (dec_cls == CL_NOP) begin
                            state_q <= ST_BARRIER;
                        end
                    end
                end
                ST_FETCH: begin
                    if (take) begin
                        left_q <= left_q - 2'd1;
                        if (last) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_BARRIER: begin
                    if (leave_nop) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    imm_assemble #(.WORD_W(WORD_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .load    (take),
        .last    (last),
        .size    (size_q),
        .word_in (ext_data),
        .value   (imm_value),
        .valid   (imm_valid)
    );

    imm_pc_counter #(.PC_W(PC_W), .WORD_W(WORD_W), .PC_RESET(PC_RESET)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pc_step),
        .pc    (pc)
    );

    // Purpose: report the size code of the delivered immediate.
    assign imm_size = size_q;
endmodule

// File: rtl/imm_fetch_seq_chk.sv
// Checker for the fetch sequencer, attached through bind.
// Assumes the PC is never reloaded from outside the block.
module imm_fetch_seq_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_ready,
    input logic            ext_ready,
    input logic            ext_valid,
    input logic            bus_pending,
    input logic            imm_valid,
    input logic            illegal,
    input logic            nop_done,
    input logic [PC_W-1:0] pc
);
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({imm_valid, illegal, nop_done})); // R9
    AST_IMM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        imm_valid |=> !imm_valid); // R9
    AST_IMM_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        imm_valid |-> op_ready); // R9
    AST_WAIT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ready && !ext_valid) |=> $stable(pc)); // R7
    AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_ready && op_ready)); // R7
    AST_PC_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> (pc == $past(pc) + PC_W'(2))); // R8
    AST_BAD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!ext_ready && op_ready)); // R6
    AST_BARRIER_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        nop_done |-> !$past(bus_pending)); // R10
    AST_BARRIER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        nop_done |=> !nop_done); // R10
endmodule

bind imm_fetch_seq imm_fetch_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_ready    (op_ready),
    .ext_ready   (ext_ready),
    .ext_valid   (ext_valid),
    .bus_pending (bus_pending),
    .imm_valid   (imm_valid),
    .illegal     (illegal),
    .nop_done    (nop_done),
    .pc          (pc)
);

// File: tb/imm_fetch_seq_test.sv
module imm_fetch_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic        op_ready;
    logic        bus_pending = 1'b0;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_data = '0;
    logic        ext_ready;
    logic        imm_valid;
    logic [31:0] imm_value;
    logic [1:0]  imm_size;
    logic        illegal;
    logic        nop_done;
    logic [31:0] pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_pc;
    logic [31:0] last_imm;

    always #2 clk = ~clk;

    imm_fetch_seq uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .op_ready(op_ready), .bus_pending(bus_pending), .ext_valid(ext_valid),
        .ext_data(ext_data), .ext_ready(ext_ready), .imm_valid(imm_valid),
        .imm_value(imm_value), .imm_size(imm_size), .illegal(illegal),
        .nop_done(nop_done), .pc(pc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_op(input logic [15:0] op);
        @(negedge clk);
        chk(op_ready == 1'b1, "R2 op_ready before opcode", 32'(op_ready), 32'd1);
        op_valid = 1'b1;
        opcode   = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic run_imm(input logic [1:0] sz, input logic [15:0] w1,
                           input logic [15:0] w2, input int stall);
        logic [31:0] exp_val;
        int nwords;
        send_op({8'h00, sz, 6'b000000});
        exp_pc += 2;
        chk(pc == exp_pc, "R2 pc after opcode", pc, exp_pc);
        if (sz == 2'b11) begin
            chk(illegal == 1'b1, "R6 illegal pulse", 32'(illegal), 32'd1);
            chk(ext_ready == 1'b0, "R6 no fetch", 32'(ext_ready), 32'd0);
            @(negedge clk);
            chk(illegal == 1'b0, "R6 pulse ends", 32'(illegal), 32'd0);
            chk(pc == exp_pc, "R6 pc unchanged", pc, exp_pc);
            return;
        end
        nwords = (sz == 2'b10) ? 2 : 1;
        for (int i = 0; i < nwords; i++) begin
            for (int s = 0; s < stall; s++) begin
                chk(ext_ready == 1'b1, "R7 hold request", 32'(ext_ready), 32'd1);
                chk(pc == exp_pc, "R7 pc held", pc, exp_pc);
                chk(imm_valid == 1'b0, "R7 no pulse", 32'(imm_valid), 32'd0);
                @(negedge clk);
            end
            chk(ext_ready == 1'b1, "R7 request", 32'(ext_ready), 32'd1);
            ext_valid = 1'b1;
            ext_data  = (i == 0) ? w1 : w2;
            @(negedge clk);
            ext_valid = 1'b0;
            exp_pc += 2;
            chk(pc == exp_pc, "R8 pc per word", pc, exp_pc);
        end
        case (sz)
            2'b00:   exp_val = {24'h0, w1[7:0]};
            2'b01:   exp_val = {16'h0, w1};
            default: exp_val = {w1, w2};
        endcase
        chk(imm_valid == 1'b1, "R9 imm_valid", 32'(imm_valid), 32'd1);
        chk(imm_value == exp_val, (sz == 2'b00) ? "R3 byte value" :
            (sz == 2'b01) ? "R4 word value" : "R5 long value", imm_value, exp_val);
        chk(imm_size == sz, "R9 imm_size", 32'(imm_size), 32'(sz));
        chk(op_ready == 1'b1, "R9 idle in pulse", 32'(op_ready), 32'd1);
        last_imm = exp_val;
        @(negedge clk);
        chk(imm_valid == 1'b0, "R9 single cycle", 32'(imm_valid), 32'd0);
    endtask

    task automatic run_nop(input int pend);
        @(negedge clk);
        bus_pending = (pend > 0);
        send_op(16'h4E71);
        for (int s = 0; s < pend; s++) begin
            chk(op_ready == 1'b0, "R10 busy while pending", 32'(op_ready), 32'd0);
            chk(nop_done == 1'b0, "R10 no early done", 32'(nop_done), 32'd0);
            chk(pc == exp_pc, "R10 pc waits", pc, exp_pc);
            @(negedge clk);
        end
        bus_pending = 1'b0;
        @(negedge clk);
        exp_pc += 2;
        chk(nop_done == 1'b1, "R10 done pulse", 32'(nop_done), 32'd1);
        chk(pc == exp_pc, "R10 pc step", pc, exp_pc);
        chk(imm_value == last_imm, "R10 imm kept", imm_value, last_imm);
        @(negedge clk);
        chk(nop_done == 1'b0, "R10 pulse ends", 32'(nop_done), 32'd0);
    endtask

    task automatic run_other(input logic [15:0] op);
        send_op(op);
        exp_pc += 2;
        chk(pc == exp_pc, "R11 pc step", pc, exp_pc);
        chk(ext_ready == 1'b0, "R11 no fetch", 32'(ext_ready), 32'd0);
        chk({imm_valid, illegal, nop_done} == 3'b000, "R11 no pulse",
            32'({imm_valid, illegal, nop_done}), 32'd0);
        @(negedge clk);
        chk(op_ready == 1'b1, "R11 idle", 32'(op_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_pc = 32'h0000_1000;
        last_imm = 32'h0;
        chk(op_ready == 1'b1, "R1 op_ready", 32'(op_ready), 32'd1);
        chk(ext_ready == 1'b0, "R1 ext_ready", 32'(ext_ready), 32'd0);
        chk({imm_valid, illegal, nop_done} == 3'b000, "R1 pulses",
            32'({imm_valid, illegal, nop_done}), 32'd0);
        chk(pc == exp_pc, "R1 pc", pc, exp_pc);
        chk(imm_value == 32'h0, "R1 imm_value", imm_value, 32'h0);
        for (int sz = 0; sz < 4; sz++) begin
            for (int p = 0; p < 6; p++) begin
                for (int st = 0; st < 3; st++) begin
                    logic [15:0] a, b;
                    a = (16'h8000 >> (p * 3)) ^ 16'(p * 16'h1357 + sz * 16'h0F0F);
                    b = ~a ^ 16'(st * 16'h2461 + p);
                    run_imm(2'(sz), a, b, st);
                end
            end
        end
        for (int n = 0; n < 4; n++) run_nop(n);
        run_other(16'h4E70);
        run_other(16'h0100);
        run_other(16'hFFFF);
        run_other(16'h4E72);
        run_imm(2'b10, 16'hFFFF, 16'h0000, 1);
        run_nop(2);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule